// File: doc/BRIEF.md
# Alarm-Aligned Periodic Pulse Generator

This block turns the drift-compensated tick of a precision time counter into periodic pulse trains. It has three channels, and each channel has its own interval register. Software disables the timer and loads the intervals. It then arms the generator with a start bit and re-enables the timer. The trains stay silent until the alarm-match strobe from the time counter arrives. The alarm is placed one counter step before a whole-second boundary, so the first pulse falls on that boundary and later pulses keep that phase.

Each interval value is the wanted period in nanoseconds minus one counter step. With a 10 ns step, 999,999,990 gives one pulse per second and 99,990 gives one pulse every 100 us. Every pulse latches a per-channel event flag. The flags of the first two channels can be masked onto an interrupt line, and the pulses of those two channels can also be looped back as internal trigger strobes. A separate 16-bit prescaler divides the tick into an output clock. A realign-off control lets the trains start without waiting for the alarm.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset, `pulse_out`, `loop_trig`, `event_flags`, `irq` and `clk_div_out` are all zero, and the prescale factor is 100.
- R2: With the timer enabled, the start bit set and realign-off low, no pulse appears on any channel until `alarm_hit` is seen.
- R3: Once running, channel i fires on the first tick, then every floor(interval_i / 10) + 1 ticks, with a step of 10. Intervals are written at address 0 (channel 1), 1 (channel 2) and 2 (channel 3).
- R4: A firing tick raises the channel's pulse in the next cycle. The pulse holds until the next tick, so it is one tick period wide and never changes between ticks.
- R5: A pulse on channel 1, 2 or 3 sets `event_flags` bit 7, 6 or 5 respectively. Writing to address 4 clears every flag whose data bit is 1 and leaves the others.
- R6: `irq` is the OR of flag 7 gated by mask bit 7 and flag 6 gated by mask bit 6, where the mask is written at address 5, data bits 7 and 6. Flag 5 never reaches `irq`.
- R7: Dropping `tmr_en` clears all pulses at the next edge, stops the channels and drops the armed state. After re-enabling, pulses wait for a fresh `alarm_hit`.
- R8: With `realign_off` high, enable plus start runs the channels at once, and the first tick fires every channel.
- R9: `loop_trig[0]` equals channel 1's pulse gated by `loop_en[0]`, and `loop_trig[1]` equals channel 2's pulse gated by `loop_en[1]`.
- R10: With N the prescale factor (address 4'h3, low 16 bits) and values below 2 taken as 2, `clk_div_out` after k ticks since enable is high exactly when (k mod N) < N/2. It is low while the timer is disabled.
- R11: An `alarm_hit` that arrives while the channels are running does not disturb the cadence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Drift-compensated counter step strobe |
| alarm_hit | input | 1 | Alarm-match strobe from the time counter |
| tmr_en | input | 1 | Timer enable |
| start_req | input | 1 | Start indication (arms the generator) |
| realign_off | input | 1 | Start without waiting for the alarm |
| loop_en | input | 2 | Internal loopback enables for channels 1 and 2 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0-2 intervals, 3 prescale, 4 flag clear, 5 mask |
| wr_data | input | 32 | Write data |
| pulse_out | output | 3 | Pulse lines, bit 0 is channel 1 |
| loop_trig | output | 2 | Looped-back pulse strobes |
| event_flags | output | 8 | Sticky pulse event flags (bits 7, 6, 5) |
| irq | output | 1 | Masked event interrupt |
| clk_div_out | output | 1 | Prescaled output clock |

## Verification
The assertions take three things about the inputs for granted. The first is that `tick` and `alarm_hit` are single-cycle strobes. The second is that intervals and prescale are written only while the timer is disabled. The third is that the time counter produces the alarm in a cycle apart from a tick. The stimulus keeps to these. It separates ticks with idle cycles, drives alarms only on idle cycles, and writes registers only inside the disabled window of each round. Random intervals include values that are not whole multiples of the step. Random prescale factors include the values 0 and 1.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int CNT_W  = 32;
  localparam int PRSC_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } arm_state_t;

  // A count below one step means the interval has run out on this tick.
  function automatic logic cnt_expired(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] step);
    return cnt < step;
  endfunction

  // Next count on a tick: reload on expiry, otherwise step down.
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] cnt,
                                                input logic [CNT_W-1:0] step,
                                                input logic [CNT_W-1:0] reload);
    return cnt_expired(cnt, step) ? reload : cnt - step;
  endfunction

  // Division factor actually used; factors below two act as two.
  function automatic logic [PRSC_W-1:0] div_factor(input logic [PRSC_W-1:0] f);
    return (f < PRSC_W'(2)) ? PRSC_W'(2) : f;
  endfunction
endpackage

// File: rtl/ptg_arm_fsm.sv
module ptg_arm_fsm
  import ptg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_en,
  input  logic start_req,
  input  logic realign_off,
  input  logic alarm_hit,
  output logic run
);
  arm_state_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (!tmr_en) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (start_req) st_q <= realign_off ? ST_RUN : ST_ARMED;
        ST_ARMED: if (realign_off || alarm_hit) st_q <= ST_RUN;
        ST_RUN:   st_q <= ST_RUN;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign run = (st_q == ST_RUN) && tmr_en;
endmodule

// File: rtl/ptg_channel.sv
module ptg_channel
  import ptg_pkg::*;
#(
  parameter int STEP = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] interval,
  output logic             pulse,
  output logic             fire
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  logic [CNT_W-1:0] cnt_q;

  assign fire = run && tick && cnt_expired(cnt_q, STEP_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (tick) begin
      cnt_q <= cnt_next(cnt_q, STEP_V, interval);
      pulse <= fire;
    end
  end
endmodule

// File: rtl/ptg_clkdiv.sv
module ptg_clkdiv
  import ptg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic [PRSC_W-1:0] factor,
  output logic              clk_out
);
  logic [PRSC_W-1:0] pcnt_q;
  logic [PRSC_W-1:0] eff;

  assign eff = div_factor(factor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (!en) begin
      pcnt_q <= '0;
    end else if (tick) begin
      pcnt_q <= (pcnt_q >= eff - PRSC_W'(1)) ? '0 : pcnt_q + PRSC_W'(1);
    end
  end

  assign clk_out = en && (pcnt_q < (eff >> 1));
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
  import ptg_pkg::*;
#(
  parameter int NCH          = 3,
  parameter int STEP_NS      = 10,
  parameter int PRSC_DEFAULT = 100,
  parameter int EVW          = 8,
  parameter int AW           = 3,
  parameter int DW           = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           alarm_hit,
  input  logic           tmr_en,
  input  logic           start_req,
  input  logic           realign_off,
  input  logic [1:0]     loop_en,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] pulse_out,
  output logic [1:0]     loop_trig,
  output logic [EVW-1:0] event_flags,
  output logic           irq,
  output logic           clk_div_out
);
  localparam int MSK_N   = 2;
  localparam int EVT_TOP = EVW - 1;
  localparam logic [AW-1:0] A_PRSC = AW'(NCH);
  localparam logic [AW-1:0] A_EVT  = AW'(NCH + 1);
  localparam logic [AW-1:0] A_MSK  = AW'(NCH + 2);

  logic                  run_w;
  logic [NCH-1:0]        fire_w;
  logic [NCH-1:0]        pulse_w;
  logic [CNT_W-1:0]      ivl_q [NCH];
  logic [PRSC_W-1:0]     prsc_q;
  logic [MSK_N-1:0]      mask_q;
  logic [EVW-1:0]        evt_q;
  logic [EVW-1:0]        evt_set;
  logic [EVW-1:0]        evt_clr;

  ptg_arm_fsm u_arm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_en      (tmr_en),
    .start_req   (start_req),
    .realign_off (realign_off),
    .alarm_hit   (alarm_hit),
    .run         (run_w)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ivl_q[i] <= '0;
      else if (wr_en && wr_addr == AW'(i)) ivl_q[i] <= CNT_W'(wr_data);
    end

    ptg_channel #(.STEP(STEP_NS)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_w),
      .tick     (tick),
      .interval (ivl_q[i]),
      .pulse    (pulse_w[i]),
      .fire     (fire_w[i])
    );
  end

  always_comb begin
    evt_set = '0;
    for (int i = 0; i < NCH; i++) evt_set[EVT_TOP - i] = fire_w[i];
  end

  assign evt_clr = (wr_en && wr_addr == A_EVT) ? wr_data[EVW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      prsc_q <= PRSC_W'(PRSC_DEFAULT);
      mask_q <= '0;
    end else begin
      evt_q <= (evt_q & ~evt_clr) | evt_set;
      if (wr_en && wr_addr == A_PRSC) prsc_q <= wr_data[PRSC_W-1:0];
      if (wr_en && wr_addr == A_MSK)  mask_q <= wr_data[EVT_TOP -: MSK_N];
    end
  end

  ptg_clkdiv u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (tmr_en),
    .tick    (tick),
    .factor  (prsc_q),
    .clk_out (clk_div_out)
  );

  assign pulse_out   = pulse_w;
  assign loop_trig   = pulse_w[1:0] & loop_en;
  assign event_flags = evt_q;
  assign irq         = |(evt_q[EVT_TOP -: MSK_N] & mask_q);
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       tmr_en,
  input logic       run_w,
  input logic [1:0] loop_en,
  input logic [2:0] pulse_out,
  input logic [1:0] loop_trig,
  input logic [7:0] event_flags,
  input logic       irq
);
  // R4: pulses only change on a tick edge (or when the timer stops)
  assert_pulse_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && tmr_en) |=> $stable(pulse_out));

  // R3: a rising pulse was caused by a tick in the previous cycle
  assert_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pulse_out & ~$past(pulse_out))) |-> $past(tick));

  // R7: disabling the timer clears every pulse at the next edge
  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> (pulse_out == 3'b000));

  // R2: nothing pulses while the sequencer is not running
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |=> (pulse_out == 3'b000));

  // R5: each channel's rising pulse leaves its flag set
  assert_flag_ch1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out[0]) |-> event_flags[7]);
  assert_flag_ch2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out[1]) |-> event_flags[6]);
  assert_flag_ch3_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out[2]) |-> event_flags[5]);

  // R6: no interrupt without a pending maskable flag
  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (event_flags[7:6] == 2'b00) |-> !irq);

  // R9: a loopback strobe needs both the pulse and its enable
  assert_loop_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_trig & ~(pulse_out[1:0] & loop_en)) == 2'b00);
endmodule

bind pulse_train_gen ptg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .tmr_en      (tmr_en),
  .run_w       (run_w),
  .loop_en     (loop_en),
  .pulse_out   (pulse_out),
  .loop_trig   (loop_trig),
  .event_flags (event_flags),
  .irq         (irq)
);

// File: tb/tb_pulse_train_gen.sv
module tb_pulse_train_gen;
  localparam int CYC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        alarm_hit = 1'b0;
  logic        tmr_en = 1'b0;
  logic        start_req = 1'b0;
  logic        realign_off = 1'b0;
  logic [1:0]  loop_en = 2'b00;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  pulse_out;
  logic [1:0]  loop_trig;
  logic [7:0]  event_flags;
  logic        irq;
  logic        clk_div_out;

  int n_cmp = 0;
  int n_bad = 0;

  pulse_train_gen dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .alarm_hit(alarm_hit),
    .tmr_en(tmr_en), .start_req(start_req), .realign_off(realign_off),
    .loop_en(loop_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pulse_out(pulse_out), .loop_trig(loop_trig), .event_flags(event_flags),
    .irq(irq), .clk_div_out(clk_div_out)
  );

  always #(CYC/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Tick k (counting from 1 after the start) fires when (k-1) is a multiple of the tick period.
  function automatic logic exp_fire(input int k, input int ivl);
    return ((k - 1) % (ivl / 10 + 1)) == 0;
  endfunction

  function automatic logic exp_div(input int kd, input int pr);
    int n;
    n = (pr < 2) ? 2 : pr;
    return (kd % n) < (n / 2);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_alarm();
    alarm_hit = 1'b1;
    @(negedge clk);
    alarm_hit = 1'b0;
  endtask

  task automatic run_round(input int iv0, input int iv1, input int iv2, input int pr,
                           input bit ra_off, input logic [1:0] lpe, input logic [1:0] msk,
                           input int npre, input int nrun, input int alarm_at);
    int ivs[3];
    logic [7:0] ev;
    logic [2:0] expp;
    int kd;
    ivs[0] = iv0; ivs[1] = iv1; ivs[2] = iv2;
    tmr_en = 1'b0; start_req = 1'b0;
    @(negedge clk);
    check("R7 pulses cleared when disabled", {29'd0, pulse_out}, 32'd0);
    check("R10 divider low when disabled", {31'd0, clk_div_out}, 32'd0);
    wr(3'd0, iv0); wr(3'd1, iv1); wr(3'd2, iv2);
    wr(3'd3, pr); wr(3'd4, 32'hFF); wr(3'd5, {24'd0, msk, 6'd0});
    loop_en = lpe; realign_off = ra_off;
    tmr_en = 1'b1; start_req = 1'b1;
    @(negedge clk);
    kd = 0;
    check("R10 divider phase at enable", {31'd0, clk_div_out}, {31'd0, exp_div(kd, pr)});
    if (!ra_off) begin
      for (int j = 0; j < npre; j++) begin
        do_tick(); kd++;
        check("R2 no pulse before alarm", {29'd0, pulse_out}, 32'd0);
        check("R10 divider", {31'd0, clk_div_out}, {31'd0, exp_div(kd, pr)});
        @(negedge clk);
      end
      do_alarm();
    end
    ev = 8'h00;
    for (int j = 1; j <= nrun; j++) begin
      if (j == alarm_at) do_alarm();  // R11: late alarm must be ignored
      do_tick(); kd++;
      for (int c = 0; c < 3; c++) begin
        expp[c] = exp_fire(j, ivs[c]);
        if (expp[c]) ev[7-c] = 1'b1;
      end
      check(ra_off ? "R8 immediate run cadence" : "R3 R11 pulse cadence",
            {29'd0, pulse_out}, {29'd0, expp});
      check("R9 loopback", {30'd0, loop_trig}, {30'd0, expp[1:0] & lpe});
      check("R10 divider", {31'd0, clk_div_out}, {31'd0, exp_div(kd, pr)});
      @(negedge clk);
      check("R4 pulse held between ticks", {29'd0, pulse_out}, {29'd0, expp});
    end
    check("R5 event flags", {24'd0, event_flags}, {24'd0, ev});
    check("R6 masked irq", {31'd0, irq}, {31'd0, |(ev[7:6] & msk)});
  endtask

  initial begin
    #(CYC * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset pulses", {29'd0, pulse_out}, 32'd0);
    check("R1 reset loop", {30'd0, loop_trig}, 32'd0);
    check("R1 reset flags", {24'd0, event_flags}, 32'd0);
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    check("R1 reset divider", {31'd0, clk_div_out}, 32'd0);

    // R1 R10: default factor 100 with the timer enabled, not armed
    tmr_en = 1'b1;
    @(negedge clk);
    for (int kd = 0; kd <= 102; kd++) begin
      check("R1 R10 default prescale", {31'd0, clk_div_out}, {31'd0, exp_div(kd, 100)});
      check("R2 unarmed quiet", {29'd0, pulse_out}, 32'd0);
      do_tick();
    end

    // Directed cases
    run_round(30, 50, 0, 4, 1'b0, 2'b11, 2'b11, 3, 30, 0);
    run_round(35, 19, 9, 0, 1'b1, 2'b01, 2'b10, 0, 20, 7);
    run_round(90, 10, 20, 1, 1'b0, 2'b10, 2'b01, 5, 25, 12);

    // Random rounds
    for (int r = 0; r < 8; r++) begin
      run_round($urandom_range(0, 80), $urandom_range(0, 80), $urandom_range(0, 80),
                $urandom_range(0, 9), (r % 4) == 3, 2'($urandom_range(0, 3)),
                2'($urandom_range(0, 3)), $urandom_range(0, 4), 40, $urandom_range(2, 39));
    end

    // R7: disabling mid-run drops the arm; restart waits for a new alarm
    realign_off = 1'b0;
    tmr_en = 1'b0;
    @(negedge clk);
    check("R7 disable clears pulses", {29'd0, pulse_out}, 32'd0);
    tmr_en = 1'b1; start_req = 1'b1;
    @(negedge clk);
    for (int j = 0; j < 4; j++) begin
      do_tick();
      check("R7 restart waits for alarm", {29'd0, pulse_out}, 32'd0);
      @(negedge clk);
    end
    do_alarm();
    do_tick();
    check("R7 first pulse after new alarm", {29'd0, pulse_out}, 32'd7);

    // R5 selective clear, R6 mask steering
    @(negedge clk);
    check("R5 all flags set", {24'd0, event_flags}, 32'hE0);
    wr(3'd4, 32'h80);
    check("R5 clear only bit 7", {24'd0, event_flags}, 32'h60);
    wr(3'd5, 32'h40);
    check("R6 mask bit 6 passes flag 6", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'h80);
    check("R6 flag 7 cleared so no irq", {31'd0, irq}, 32'd0);
    wr(3'd4, 32'h40);
    wr(3'd5, 32'hFF);
    check("R6 flag 5 never reaches irq", {31'd0, irq}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule